// File: doc/BRIEF.md
# Bulk/Interrupt OUT Endpoint Receive Controller

This block sits behind a packet engine on the device side of a USB function and handles one OUT endpoint carrying Bulk or Interrupt traffic. For every data packet the engine reports a start strobe with the packet's data PID (DATA0 or DATA1), a stream of payload bytes, and an end strobe with a CRC verdict. The controller stores accepted payload in a buffer of one or two packet slots, tracks the expected data toggle, and answers each packet with ACK, NAK, STALL or no handshake at all.

Software drives the endpoint through one 8-bit control/status byte. From it software sees whether a packet is waiting, releases or flushes a held packet, sets and clears a sticky stall, acknowledges that a STALL was sent, and re-arms the toggle sequence at DATA0. Software also reads the length of the oldest held packet and its bytes through a random-access read port. An interrupt line is high while a packet is waiting or a stall-sent event has not been acknowledged. A packet shorter than the maximum packet size, a zero-length one included, marks the end of a transfer. It is stored and presented like any other packet.

Top module: `out_ep_rx_ctrl`

## Requirements
- R1: In the control/status byte, bit 0 reads 1 while a packet is held, and a write with bit 0 set releases it. A write with bit 4 set flushes one packet. Bit 5 is the stall request and takes the written value on every write. Bit 6 reads the stall-sent flag, and a write with bit 6 set clears it. A write with bit 7 set clears the toggle. Bits 1 to 4 and 7 read 0.
- R2: A packet with good CRC and length no more than `max_pkt` is stored and answered with ACK when three things hold: its PID (0 = DATA0, 1 = DATA1) equals the expected toggle, a slot is free, and no stall is requested. Bit 0 then reads 1, `irq` rises, and the expected toggle flips. Zero-length packets are included.
- R3: `rx_count` gives the byte count of the oldest held packet, or 0 when none is held. `rd_data` returns byte `rd_addr` of that packet one clock after the address. Releasing a packet makes the next held packet, if any, the current one.
- R4: With double buffering, two packets can be held at once. A packet that arrives while every slot is occupied gets NAK (code 2). Nothing is stored and the toggle stays as it was.
- R5: A packet whose PID differs from the expected toggle gets ACK, but its data is discarded and the toggle stays as it was.
- R6: A packet with a bad CRC, or longer than `max_pkt`, gets no handshake. It changes neither the held packets nor the toggle.
- R7: Each flush write discards one held packet. With two packets held, two flush writes are needed to empty the buffer.
- R8: While the stall request is set, every valid packet gets STALL (code 3). It is not stored, and the stall-sent flag and `irq` are set. This applies to each later packet too.
- R9: The stall-sent flag stays set until a write clears it. Clearing it leaves the stall request as written.
- R10: After a toggle-clear write, the next packet accepted must carry DATA0.
- R11: A write takes effect on the second clock edge after it when no packet is in progress. A write made during a packet takes effect on the first edge after that packet's end cycle, so the packet is judged by the settings in force when it started.
- R12: `hs_valid` is high for exactly the one cycle after the end-strobe cycle, with `hs_code` 1 = ACK, 2 = NAK, 3 = STALL. The end strobe comes in a cycle of its own, after the last byte.
- R13: After reset, the buffer is empty, the stall request and stall-sent flags are clear, `irq` and `hs_valid` are low, and the expected toggle is DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | Start of a data packet |
| pkt_pid | input | 1 | Data PID of the starting packet, 0 = DATA0, 1 = DATA1 |
| pkt_byte_valid | input | 1 | A payload byte is present |
| pkt_byte | input | 8 | Payload byte |
| pkt_end | input | 1 | End of packet, in its own cycle |
| pkt_crc_ok | input | 1 | CRC verdict, sampled with `pkt_end` |
| max_pkt | input | CNT_W | Maximum packet size in bytes, at most MAX_BYTES |
| hs_valid | output | 1 | Handshake decision present |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| csr_wr | input | 1 | Write strobe for the control/status byte |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Current control/status value |
| rx_count | output | CNT_W | Length of the oldest held packet |
| rd_addr | input | AW | Byte index into the oldest held packet |
| rd_data | output | 8 | Byte read, one clock after the address |
| irq | output | 1 | Packet held or stall sent and unacknowledged |

## Verification
The handshake is registered on the edge that closes the end-strobe cycle. The held-packet count, `rx_count`, bit 0 and the stall-sent flag change on that same edge. The bench therefore checks them all at the falling edge right after it, and checks one cycle later that the handshake has dropped. A control write is sampled on one edge and applied on the next idle edge. The bench lets both edges pass before it checks the effect. Mid-packet writes are checked twice: at the handshake sample, to confirm they are still pending, and one cycle later, to confirm they have landed. Buffer reads are checked at the falling edge after the edge that captured the address.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  localparam int B_READY = 0;
  localparam int B_FLUSH = 4;
  localparam int B_STALL = 5;
  localparam int B_SENT  = 6;
  localparam int B_TCLR  = 7;
endpackage

// File: rtl/oep_slot_buffer.sv
module oep_slot_buffer #(
  parameter int MAX_BYTES = 64,
  parameter int NSLOT     = 2,
  parameter int CNT_W     = 7,
  parameter int AW        = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             commit,
  input  logic [CNT_W-1:0] commit_len,
  input  logic             pop,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic [1:0]       occ,
  output logic [CNT_W-1:0] head_len
);
  localparam int DEPTH = NSLOT * MAX_BYTES;
  localparam int DAW   = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] len_q [NSLOT];
  logic             wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [1:0]       occ_q;
  logic [DAW-1:0]   waddr, raddr;

  generate
    if (NSLOT > 1) begin : g_two_slots
      assign wr_nxt = ~wr_ptr;
      assign rd_nxt = ~rd_ptr;
    end else begin : g_one_slot
      assign wr_nxt = 1'b0;
      assign rd_nxt = 1'b0;
    end
  endgenerate

  assign waddr = DAW'(32'(wr_ptr) * MAX_BYTES + 32'(wr_addr));
  assign raddr = DAW'(32'(rd_ptr) * MAX_BYTES + 32'(rd_addr));

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wr_data;
    rd_data <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= 1'b0;
      rd_ptr <= 1'b0;
      occ_q  <= 2'd0;
      for (int i = 0; i < NSLOT; i++) len_q[i] <= '0;
    end else begin
      if (commit) begin
        len_q[wr_ptr] <= commit_len;
        wr_ptr        <= wr_nxt;
      end
      if (pop) rd_ptr <= rd_nxt;
      occ_q <= occ_q + 2'(commit) - 2'(pop);
    end
  end

  assign occ      = occ_q;
  assign head_len = len_q[rd_ptr];

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    32'(occ_q) <= NSLOT);
  assert_commit_room_R4: assert property (@(posedge clk) disable iff (rst)
    commit |-> 32'(occ_q) < NSLOT);
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> occ_q != 2'd0);
endmodule

// File: rtl/oep_cmd_ctrl.sv
module oep_cmd_ctrl
  import oep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csr_wr,
  input  logic [7:0] csr_wdata,
  input  logic       busy,
  input  logic [1:0] occ,
  input  logic       sent_evt,
  output logic       pop,
  output logic       tclr,
  output logic       stall_req,
  output logic       sent_flag
);
  logic [1:0] pend_pops, pops_left, pops_nxt;
  logic       pend_tclr, pend_sclr, pend_swr, pend_sval;
  logic       apply, new_pop;
  logic       unused_wbits;

  assign unused_wbits = ^csr_wdata[3:1];
  assign apply   = !busy;
  assign new_pop = csr_wr && (csr_wdata[B_READY] || csr_wdata[B_FLUSH]);
  assign pop     = apply && (pend_pops != 2'd0) && (occ != 2'd0);
  assign tclr    = apply && pend_tclr;

  always_comb begin
    pops_left = pend_pops;
    if (apply && pend_pops != 2'd0)
      pops_left = (occ != 2'd0) ? 2'(pend_pops - 2'd1) : 2'd0;
    pops_nxt = (new_pop && pops_left != 2'd3) ? 2'(pops_left + 2'd1) : pops_left;
  end

  logic stall_q, sent_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_pops <= 2'd0;
      pend_tclr <= 1'b0;
      pend_sclr <= 1'b0;
      pend_swr  <= 1'b0;
      pend_sval <= 1'b0;
      stall_q   <= 1'b0;
      sent_q    <= 1'b0;
    end else begin
      pend_pops <= pops_nxt;
      pend_tclr <= (pend_tclr && !apply) || (csr_wr && csr_wdata[B_TCLR]);
      pend_sclr <= (pend_sclr && !apply) || (csr_wr && csr_wdata[B_SENT]);
      pend_swr  <= (pend_swr && !apply) || csr_wr;
      if (csr_wr) pend_sval <= csr_wdata[B_STALL];
      if (apply && pend_swr) stall_q <= pend_sval;
      if (sent_evt) sent_q <= 1'b1;
      else if (apply && pend_sclr) sent_q <= 1'b0;
    end
  end

  assign stall_req = stall_q;
  assign sent_flag = sent_q;

  assert_sent_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    sent_evt |=> sent_q);
  assert_sent_clear_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(sent_q) |-> $past(pend_sclr && !busy));
  assert_defer_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(stall_q) |-> $past(!busy));
endmodule

// File: rtl/oep_rx_track.sv
module oep_rx_track
  import oep_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int NSLOT     = 2,
  parameter int CNT_W     = 7,
  parameter int AW        = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_start,
  input  logic             pkt_pid,
  input  logic             pkt_byte_valid,
  input  logic [7:0]       pkt_byte,
  input  logic             pkt_end,
  input  logic             pkt_crc_ok,
  input  logic [CNT_W-1:0] max_pkt,
  input  logic             stall_req,
  input  logic [1:0]       occ,
  input  logic             tclr,
  output logic             busy,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             commit,
  output logic [CNT_W-1:0] commit_len,
  output logic             sent_evt,
  output logic             hs_valid,
  output logic [1:0]       hs_code
);
  logic             in_pkt, pid_q, exp_q, hs_valid_q;
  logic [CNT_W-1:0] cnt_q;
  hs_e              code, hs_code_q;
  logic             has_room, pid_match, store_ok, ending, frame_ok;

  assign has_room  = 32'(occ) < NSLOT;
  assign pid_match = (pid_q == exp_q);
  assign store_ok  = !stall_req && has_room && pid_match;
  assign ending    = in_pkt && pkt_end;
  assign frame_ok  = pkt_crc_ok && (cnt_q <= max_pkt);
  assign busy      = in_pkt || pkt_start;

  assign wr_en      = in_pkt && pkt_byte_valid && store_ok && (cnt_q < CNT_W'(MAX_BYTES));
  assign wr_addr    = cnt_q[AW-1:0];
  assign wr_data    = pkt_byte;
  assign commit_len = cnt_q;

  always_comb begin
    code     = HS_NONE;
    commit   = 1'b0;
    sent_evt = 1'b0;
    if (ending && frame_ok) begin
      if (stall_req) begin
        code     = HS_STALL;
        sent_evt = 1'b1;
      end else if (!has_room) begin
        code = HS_NAK;
      end else begin
        code   = HS_ACK;
        commit = pid_match;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt     <= 1'b0;
      pid_q      <= 1'b0;
      exp_q      <= 1'b0;
      cnt_q      <= '0;
      hs_valid_q <= 1'b0;
      hs_code_q  <= HS_NONE;
    end else begin
      hs_valid_q <= (code != HS_NONE);
      hs_code_q  <= code;
      if (pkt_start) begin
        in_pkt <= 1'b1;
        pid_q  <= pkt_pid;
        cnt_q  <= '0;
      end else if (ending) begin
        in_pkt <= 1'b0;
      end else if (in_pkt && pkt_byte_valid && cnt_q <= CNT_W'(MAX_BYTES)) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (commit) exp_q <= ~exp_q;
      else if (tclr) exp_q <= 1'b0;
    end
  end

  assign hs_valid = hs_valid_q;
  assign hs_code  = hs_code_q;

  assert_hs_after_end_R12: assert property (@(posedge clk) disable iff (rst)
    hs_valid_q |-> $past(in_pkt && pkt_end));
  assert_hs_single_R12: assert property (@(posedge clk) disable iff (rst)
    hs_valid_q |=> !hs_valid_q);
  assert_toggle_move_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(exp_q) |-> $past((ending && pkt_crc_ok && pid_match && !stall_req) || tclr));
endmodule

// File: rtl/out_ep_rx_ctrl.sv
module out_ep_rx_ctrl
  import oep_pkg::*;
#(
  parameter int  MAX_BYTES  = 64,
  parameter bit  DOUBLE_BUF = 1'b1,
  localparam int CNT_W      = $clog2(MAX_BYTES + 2),
  localparam int AW         = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_start,
  input  logic             pkt_pid,
  input  logic             pkt_byte_valid,
  input  logic [7:0]       pkt_byte,
  input  logic             pkt_end,
  input  logic             pkt_crc_ok,
  input  logic [CNT_W-1:0] max_pkt,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  input  logic             csr_wr,
  input  logic [7:0]       csr_wdata,
  output logic [7:0]       csr_rdata,
  output logic [CNT_W-1:0] rx_count,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             irq
);
  localparam int NSLOT = DOUBLE_BUF ? 2 : 1;

  logic             busy, wr_en, commit, pop, tclr, sent_evt, stall_req, sent_flag;
  logic [AW-1:0]    wr_addr;
  logic [7:0]       wr_data;
  logic [CNT_W-1:0] commit_len, head_len;
  logic [1:0]       occ;
  logic             ready;

  oep_rx_track #(.MAX_BYTES(MAX_BYTES), .NSLOT(NSLOT), .CNT_W(CNT_W), .AW(AW)) u_track (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_pid(pkt_pid),
    .pkt_byte_valid(pkt_byte_valid), .pkt_byte(pkt_byte), .pkt_end(pkt_end),
    .pkt_crc_ok(pkt_crc_ok), .max_pkt(max_pkt), .stall_req(stall_req), .occ(occ),
    .tclr(tclr), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_len(commit_len), .sent_evt(sent_evt),
    .hs_valid(hs_valid), .hs_code(hs_code)
  );

  oep_slot_buffer #(.MAX_BYTES(MAX_BYTES), .NSLOT(NSLOT), .CNT_W(CNT_W), .AW(AW)) u_buf (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(commit), .commit_len(commit_len), .pop(pop), .rd_addr(rd_addr),
    .rd_data(rd_data), .occ(occ), .head_len(head_len)
  );

  oep_cmd_ctrl u_cmd (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata), .busy(busy),
    .occ(occ), .sent_evt(sent_evt), .pop(pop), .tclr(tclr),
    .stall_req(stall_req), .sent_flag(sent_flag)
  );

  assign ready    = (occ != 2'd0);
  assign rx_count = ready ? head_len : '0;
  assign irq      = ready || sent_flag;

  always_comb begin
    csr_rdata          = 8'h00;
    csr_rdata[B_READY] = ready;
    csr_rdata[B_STALL] = stall_req;
    csr_rdata[B_SENT]  = sent_flag;
  end

  assert_nak_full_R4: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == HS_NAK) |-> 32'(occ) == NSLOT);
  assert_stall_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (hs_valid && hs_code == HS_STALL) |-> (sent_flag && irq));
  assert_ack_ready_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (hs_valid && hs_code == HS_ACK));
endmodule

// File: tb/tb_out_ep_rx_ctrl.sv
module tb_out_ep_rx_ctrl;
  localparam int CNT_W = 7;
  localparam int AW    = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst = 1'b1;
  logic             pkt_start = 0, pkt_pid = 0, pkt_byte_valid = 0, pkt_end = 0, pkt_crc_ok = 0;
  logic [7:0]       pkt_byte = 8'h00;
  logic [CNT_W-1:0] max_pkt = 7'd8;
  logic             hs_valid, irq;
  logic [1:0]       hs_code;
  logic             csr_wr = 0;
  logic [7:0]       csr_wdata = 8'h00, csr_rdata, rd_data;
  logic [CNT_W-1:0] rx_count;
  logic [AW-1:0]    rd_addr = '0;

  out_ep_rx_ctrl dut (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .pkt_pid(pkt_pid),
    .pkt_byte_valid(pkt_byte_valid), .pkt_byte(pkt_byte), .pkt_end(pkt_end),
    .pkt_crc_ok(pkt_crc_ok), .max_pkt(max_pkt), .hs_valid(hs_valid), .hs_code(hs_code),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .rx_count(rx_count),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [7:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_pkt(input logic pid, input int len, input logic crc, input logic [7:0] base);
    @(negedge clk); pkt_start = 1'b1; pkt_pid = pid;
    @(negedge clk); pkt_start = 1'b0;
    for (int i = 0; i < len; i++) begin
      pkt_byte_valid = 1'b1; pkt_byte = base + 8'(i);
      @(negedge clk);
    end
    pkt_byte_valid = 1'b0; pkt_end = 1'b1; pkt_crc_ok = crc;
    @(negedge clk); pkt_end = 1'b0;
  endtask

  // wr | wdata | pid | len | crc | hs_valid | hs_code | ready | rx_count
  localparam logic [25:0] VEC [9] = '{
    {1'b0, 8'h00, 1'b0, 4'd8, 1'b1, 1'b1, 2'd1, 1'b1, 7'd8},
    {1'b0, 8'h00, 1'b1, 4'd3, 1'b1, 1'b1, 2'd1, 1'b1, 7'd8},
    {1'b0, 8'h00, 1'b0, 4'd2, 1'b1, 1'b1, 2'd2, 1'b1, 7'd8},
    {1'b1, 8'h01, 1'b0, 4'd0, 1'b1, 1'b1, 2'd1, 1'b1, 7'd3},
    {1'b1, 8'h01, 1'b0, 4'd4, 1'b1, 1'b1, 2'd1, 1'b1, 7'd0},
    {1'b0, 8'h00, 1'b1, 4'd4, 1'b0, 1'b0, 2'd0, 1'b1, 7'd0},
    {1'b0, 8'h00, 1'b1, 4'd9, 1'b1, 1'b0, 2'd0, 1'b1, 7'd0},
    {1'b0, 8'h00, 1'b1, 4'd5, 1'b1, 1'b1, 2'd1, 1'b1, 7'd0},
    {1'b1, 8'h01, 1'b0, 4'd1, 1'b1, 1'b1, 2'd1, 1'b1, 7'd5}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 csr after reset", csr_rdata, 0);
    chk("R13 count after reset", rx_count, 0);
    chk("R13 irq after reset", irq, 0);
    chk("R13 hs_valid after reset", hs_valid, 0);

    // Table: R2 accept, R4 full/NAK, R5 wrong toggle, R6 drops, R3 count
    for (int v = 0; v < 9; v++) begin
      logic [25:0] e;
      e = VEC[v];
      if (e[25]) csr_write(e[24:17]);
      send_pkt(e[16], int'(e[15:12]), e[11], 8'(v * 16));
      chk($sformatf("R12 R6 hs_valid vec%0d", v), hs_valid, e[10]);
      chk($sformatf("R2 R4 R5 hs_code vec%0d", v), hs_code, e[9:8]);
      chk($sformatf("R1 ready vec%0d", v), csr_rdata[0], e[7]);
      chk($sformatf("R3 rx_count vec%0d", v), rx_count, e[6:0]);
      if (v == 0) begin
        @(negedge clk);
        chk("R12 hs single cycle", hs_valid, 0);
      end
    end

    // R7: two flushes empty both slots
    csr_write(8'h10);
    chk("R7 first flush count", rx_count, 1);
    chk("R7 first flush ready", csr_rdata[0], 1);
    csr_write(8'h10);
    chk("R7 second flush ready", csr_rdata[0], 0);
    chk("R7 second flush irq", irq, 0);

    // R8 sticky stall, R9 sent flag, R10 toggle clear
    csr_write(8'h20);
    chk("R1 stall readback", csr_rdata, 8'h20);
    send_pkt(1'b1, 2, 1'b1, 8'h50);
    chk("R8 stall code", hs_code, 3);
    chk("R8 stall flags", csr_rdata, 8'h60);
    chk("R8 stall irq", irq, 1);
    chk("R8 stall not stored", rx_count, 0);
    send_pkt(1'b0, 1, 1'b1, 8'h58);
    chk("R8 stall repeats", hs_code, 3);
    csr_write(8'h60);
    chk("R9 sent cleared stall kept", csr_rdata, 8'h20);
    chk("R9 irq dropped", irq, 0);
    csr_write(8'h80);
    chk("R10 stall off", csr_rdata, 8'h00);
    send_pkt(1'b1, 2, 1'b1, 8'h60);
    chk("R10 DATA1 after clear ack", hs_code, 1);
    chk("R10 DATA1 discarded", csr_rdata[0], 0);
    send_pkt(1'b0, 3, 1'b1, 8'hA0);
    chk("R10 DATA0 stored", csr_rdata[0], 1);
    chk("R3 count of stored", rx_count, 3);
    chk("R2 irq on accept", irq, 1);
    rd_addr = 6'd2;
    @(negedge clk);
    chk("R3 read byte", rd_data, 8'hA2);

    // R11: stall write during a packet is deferred
    @(negedge clk); pkt_start = 1'b1; pkt_pid = 1'b1;
    @(negedge clk); pkt_start = 1'b0; pkt_byte_valid = 1'b1; pkt_byte = 8'hB0;
    csr_wr = 1'b1; csr_wdata = 8'h20;
    @(negedge clk); csr_wr = 1'b0; pkt_byte = 8'hB1;
    @(negedge clk); pkt_byte = 8'hB2;
    chk("R11 stall pending mid packet", csr_rdata[5], 0);
    @(negedge clk); pkt_byte = 8'hB3;
    @(negedge clk); pkt_byte_valid = 1'b0; pkt_end = 1'b1; pkt_crc_ok = 1'b1;
    @(negedge clk); pkt_end = 1'b0;
    chk("R11 packet judged before stall", hs_code, 1);
    chk("R11 stall not yet applied", csr_rdata[5], 0);
    chk("R4 second slot held, head kept", rx_count, 3);
    @(negedge clk);
    chk("R11 stall applied after end", csr_rdata, 8'h21);
    send_pkt(1'b0, 1, 1'b1, 8'hC0);
    chk("R8 stall wins over full", hs_code, 3);

    // R13: reset clears everything and re-arms DATA0
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 csr after second reset", csr_rdata, 0);
    chk("R13 count after second reset", rx_count, 0);
    chk("R13 irq after second reset", irq, 0);
    send_pkt(1'b1, 1, 1'b1, 8'hD0);
    chk("R13 DATA1 discarded after reset", csr_rdata[0], 0);
    send_pkt(1'b0, 1, 1'b1, 8'hD8);
    chk("R13 DATA0 accepted after reset", csr_rdata[0], 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule